// File: doc/BRIEF.md
# Virtual Channel Stream Splitter

A camera serial receiver delivers a single AXI4-Stream in which packets from up to four virtual channels are interleaved. This block sorts that stream into four separate AXI4-Stream masters, one per virtual channel, so that each frame-buffer writer downstream sees only its own channel. The destination tag on the input is an 8-bit data identifier. Its two low bits carry the channel number and its upper six bits carry the data type. Routing compares only the channel bits.

Each output beat carries the input TLAST and TUSER folded into its data word. A writer that has no sideband ports can still find frame starts and line ends. The data type is presented beside each output as a separate 6-bit field. Once the first beat of a packet has been routed, the choice of output is held until the last beat of that packet. A later change in the tag cannot split the packet, and it sets a sticky error flag instead. A parameter mask can switch channels off. Beats addressed to a disabled channel are still consumed, and each one is counted.

Top module: `vc_stream_splitter`

## Requirements
- R1: A packet whose first beat has sTdest[1:0]=n is delivered only on output n, in input order, with no beat lost or duplicated.
- R2: Each output word is {TLAST, TUSER, TDATA} of the input beat, with TDATA in the low bits. mTlast repeats the beat's TLAST, and the type field carries the beat's sTdest[7:2].
- R3: sTready is high for a disabled channel. For an enabled channel it is high exactly when the selected output holds no beat or its mTready is high.
- R4: While an output has TVALID high and TREADY low, its TVALID, word and type field stay unchanged.
- R5: The selected output is captured at the first beat of a packet and kept until the beat with TLAST is accepted. Changes to sTdest[1:0] in between do not reroute any beat.
- R6: An accepted beat inside a packet whose sTdest[1:0] differs from the locked channel sets destErr. The flag stays high until reset.
- R7: A beat accepted for a channel whose bit in CH_EN is 0 never appears on any output. It increments that channel's drop counter by one, and the counter saturates at its all-ones value.
- R8: Outputs come from registers. An accepted beat first shows TVALID on its output in the cycle after the accepting clock edge.
- R9: A synchronous active-low reset clears every output TVALID, the packet lock, destErr and all drop counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sTdata | input | DATA_W | Input beat payload |
| sTdest | input | 8 | Data identifier: [1:0] virtual channel, [7:2] data type |
| sTuser | input | USER_W | Input user sideband (start of frame) |
| sTlast | input | 1 | Input end-of-packet marker |
| sTvalid | input | 1 | Input beat valid |
| sTready | output | 1 | Input beat accepted when high with sTvalid |
| mTdata | output | 4*(DATA_W+USER_W+1) | Per-output word {last, user, data}, channel n at slice n |
| mTtype | output | 24 | Per-output 6-bit data type |
| mTlast | output | 4 | Per-output end-of-packet marker |
| mTvalid | output | 4 | Per-output beat valid |
| mTready | input | 4 | Per-output sink ready |
| dropCount | output | 4*CNT_W | Per-channel count of discarded beats |
| destErr | output | 1 | Sticky flag for a mid-packet channel change |

## Verification
A corrupted packet lock shows up at the ports within one beat. The next beat of the packet either lands on the wrong output or stalls on a ready signal that belongs to another channel. The bench catches the first case at the comparison of the popped word and the second at its check of sTready in the same cycle. A slice that reloads or clears at the wrong time shows up as a changed word under backpressure, or as a missing or extra beat at that output's next handshake. Drop counter and error flag values are compared on every cycle, so a wrong increment or a lost flag is seen one clock after the accepting edge.

// File: rtl/vc_split_pkg.sv
`timescale 1ns/1ps
package vc_split_pkg;
  localparam int VC_W   = 2;
  localparam int NUM_CH = 1 << VC_W;
  localparam int DEST_W = 8;
  localparam int TYPE_W = DEST_W - VC_W;

  // strobes from control to datapath, one bit per channel
  typedef struct packed {
    logic [NUM_CH-1:0] load;
    logic [NUM_CH-1:0] drop;
  } splitStrobe_t;
endpackage

// File: rtl/vc_split_ctrl.sv
`timescale 1ns/1ps
module vc_split_ctrl
  import vc_split_pkg::*;
#(
  parameter logic [NUM_CH-1:0] CH_EN = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sTvalid,
  input  logic              sTlast,
  input  logic [VC_W-1:0]   sTvc,
  input  logic [NUM_CH-1:0] sliceReady,
  output logic              sTready,
  output splitStrobe_t      strb,
  output logic              destErr
);
  logic            locked;
  logic [VC_W-1:0] lockVc;
  logic [VC_W-1:0] selVc;
  logic            selEn;
  logic            accept;

  // channel follows the lock inside a packet, the tag otherwise
  assign selVc   = locked ? lockVc : sTvc;
  assign selEn   = CH_EN[selVc];
  assign sTready = selEn ? sliceReady[selVc] : 1'b1;
  assign accept  = sTvalid & sTready;

  always_comb begin
    strb = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      strb.load[ch] = accept && selEn  && (selVc == VC_W'(ch));
      strb.drop[ch] = accept && !selEn && (selVc == VC_W'(ch));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked  <= 1'b0;
      lockVc  <= '0;
      destErr <= 1'b0;
    end else if (accept) begin
      locked <= !sTlast;
      lockVc <= selVc;
      if (locked && (sTvc != lockVc)) destErr <= 1'b1;
    end
  end
endmodule

// File: rtl/vc_split_dpath.sv
`timescale 1ns/1ps
module vc_split_dpath
  import vc_split_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int USER_W = 1,
  parameter int CNT_W  = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  splitStrobe_t                         strb,
  input  logic [DATA_W-1:0]                    sTdata,
  input  logic [USER_W-1:0]                    sTuser,
  input  logic                                 sTlast,
  input  logic [TYPE_W-1:0]                    sTtype,
  input  logic [NUM_CH-1:0]                    mTready,
  output logic [NUM_CH*(DATA_W+USER_W+1)-1:0]  mTdata,
  output logic [NUM_CH*TYPE_W-1:0]             mTtype,
  output logic [NUM_CH-1:0]                    mTlast,
  output logic [NUM_CH-1:0]                    mTvalid,
  output logic [NUM_CH-1:0]                    sliceReady,
  output logic [NUM_CH*CNT_W-1:0]              dropCount
);
  localparam int WORD_W = DATA_W + USER_W + 1;

  logic [WORD_W-1:0] inWord;
  assign inWord = {sTlast, sTuser, sTdata};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gSlice
    logic              vReg;
    logic [WORD_W-1:0] wordReg;
    logic [TYPE_W-1:0] typeReg;
    logic              lastReg;
    logic [CNT_W-1:0]  cntReg;

    assign sliceReady[ch] = !vReg || mTready[ch];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vReg   <= 1'b0;
        cntReg <= '0;
      end else begin
        if (strb.load[ch])    vReg <= 1'b1;
        else if (mTready[ch]) vReg <= 1'b0;
        if (strb.drop[ch] && (cntReg != '1)) cntReg <= cntReg + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (strb.load[ch]) begin
        wordReg <= inWord;
        typeReg <= sTtype;
        lastReg <= sTlast;
      end
    end

    assign mTvalid[ch]                     = vReg;
    assign mTdata[ch*WORD_W +: WORD_W]     = wordReg;
    assign mTtype[ch*TYPE_W +: TYPE_W]     = typeReg;
    assign mTlast[ch]                      = lastReg;
    assign dropCount[ch*CNT_W +: CNT_W]    = cntReg;
  end
endmodule

// File: rtl/vc_stream_splitter.sv
`timescale 1ns/1ps
module vc_stream_splitter
  import vc_split_pkg::*;
#(
  parameter int                DATA_W = 16,
  parameter int                USER_W = 1,
  parameter int                CNT_W  = 8,
  parameter logic [NUM_CH-1:0] CH_EN  = '1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [DATA_W-1:0]                   sTdata,
  input  logic [DEST_W-1:0]                   sTdest,
  input  logic [USER_W-1:0]                   sTuser,
  input  logic                                sTlast,
  input  logic                                sTvalid,
  output logic                                sTready,
  output logic [NUM_CH*(DATA_W+USER_W+1)-1:0] mTdata,
  output logic [NUM_CH*TYPE_W-1:0]            mTtype,
  output logic [NUM_CH-1:0]                   mTlast,
  output logic [NUM_CH-1:0]                   mTvalid,
  input  logic [NUM_CH-1:0]                   mTready,
  output logic [NUM_CH*CNT_W-1:0]             dropCount,
  output logic                                destErr
);
  splitStrobe_t      strb;
  logic [NUM_CH-1:0] sliceReady;

  vc_split_ctrl #(.CH_EN(CH_EN)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sTvalid    (sTvalid),
    .sTlast     (sTlast),
    .sTvc       (sTdest[VC_W-1:0]),
    .sliceReady (sliceReady),
    .sTready    (sTready),
    .strb       (strb),
    .destErr    (destErr)
  );

  vc_split_dpath #(.DATA_W(DATA_W), .USER_W(USER_W), .CNT_W(CNT_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .sTdata     (sTdata),
    .sTuser     (sTuser),
    .sTlast     (sTlast),
    .sTtype     (sTdest[DEST_W-1:VC_W]),
    .mTready    (mTready),
    .mTdata     (mTdata),
    .mTtype     (mTtype),
    .mTlast     (mTlast),
    .mTvalid    (mTvalid),
    .sliceReady (sliceReady),
    .dropCount  (dropCount)
  );
endmodule

// File: rtl/vc_split_chk.sv
`timescale 1ns/1ps
module vc_split_chk
  import vc_split_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int USER_W = 1,
  parameter int CNT_W  = 8
) (
  input logic                                clk,
  input logic                                rstN,
  input logic                                sTvalid,
  input logic                                sTready,
  input logic [NUM_CH*(DATA_W+USER_W+1)-1:0] mTdata,
  input logic [NUM_CH*TYPE_W-1:0]            mTtype,
  input logic [NUM_CH-1:0]                   mTvalid,
  input logic [NUM_CH-1:0]                   mTready,
  input logic [NUM_CH*CNT_W-1:0]             dropCount,
  input logic                                destErr
);
  localparam int WORD_W = DATA_W + USER_W + 1;

  // R3
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sTvalid && !sTready) |-> (|(mTvalid & ~mTready)));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    destErr |=> destErr);

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (mTvalid == '0 && !destErr && dropCount == '0));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChk
    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      (mTvalid[ch] && !mTready[ch]) |=>
        (mTvalid[ch] && $stable(mTdata[ch*WORD_W +: WORD_W]) &&
         $stable(mTtype[ch*TYPE_W +: TYPE_W])));

    // R7
    drop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (dropCount[ch*CNT_W +: CNT_W] != $past(dropCount[ch*CNT_W +: CNT_W])) |->
        (dropCount[ch*CNT_W +: CNT_W] == CNT_W'($past(dropCount[ch*CNT_W +: CNT_W]) + 1'b1)));

    // R8
    load_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(mTvalid[ch]) |-> $past(sTvalid && sTready));
  end
endmodule

bind vc_stream_splitter vc_split_chk #(
  .DATA_W(DATA_W), .USER_W(USER_W), .CNT_W(CNT_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .sTvalid   (sTvalid),
  .sTready   (sTready),
  .mTdata    (mTdata),
  .mTtype    (mTtype),
  .mTvalid   (mTvalid),
  .mTready   (mTready),
  .dropCount (dropCount),
  .destErr   (destErr)
);

// File: tb/tb_vc_stream_splitter.sv
`timescale 1ns/1ps
module tb_vc_stream_splitter;
  import vc_split_pkg::*;
  localparam int DW = 16;
  localparam int UW = 1;
  localparam int CW = 4;
  localparam int WW = DW + UW + 1;
  localparam logic [NUM_CH-1:0] EN = 4'b1011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DW-1:0] sTdata = '0;
  logic [7:0] sTdest = '0;
  logic [UW-1:0] sTuser = '0;
  logic sTlast = 1'b0;
  logic sTvalid = 1'b0;
  logic sTready;
  logic [NUM_CH*WW-1:0] mTdata;
  logic [NUM_CH*TYPE_W-1:0] mTtype;
  logic [NUM_CH-1:0] mTlast;
  logic [NUM_CH-1:0] mTvalid;
  logic [NUM_CH-1:0] mTready = '0;
  logic [NUM_CH*CW-1:0] dropCount;
  logic destErr;

  always #10 clk = ~clk;

  vc_stream_splitter #(.DATA_W(DW), .USER_W(UW), .CNT_W(CW), .CH_EN(EN)) dut (
    .clk(clk), .rstN(rstN), .sTdata(sTdata), .sTdest(sTdest), .sTuser(sTuser),
    .sTlast(sTlast), .sTvalid(sTvalid), .sTready(sTready), .mTdata(mTdata),
    .mTtype(mTtype), .mTlast(mTlast), .mTvalid(mTvalid), .mTready(mTready),
    .dropCount(dropCount), .destErr(destErr)
  );

  int checks = 0;
  int errors = 0;
  logic [TYPE_W+WW-1:0] q [NUM_CH][$];
  bit mLocked = 0;
  logic [1:0] mVc = '0;
  bit mErr = 0;
  int mDrop [NUM_CH];
  int popCnt [NUM_CH];
  bit randReady = 0;
  logic [NUM_CH-1:0] readyFix = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int satInc(input int v);
    return (v < (1 << CW) - 1) ? v + 1 : v;
  endfunction

  task automatic clearModel();
    for (int ch = 0; ch < NUM_CH; ch++) begin
      q[ch].delete();
      mDrop[ch] = 0;
    end
    mLocked = 0; mErr = 0; mVc = '0;
  endtask

  // one clock: drive ready, compare ports with the model, account for the handshake
  task automatic evalCycle(output bit acc);
    logic [1:0] eff;
    bit expRdy;
    logic [TYPE_W+WW-1:0] e;
    @(negedge clk);
    mTready = randReady ? NUM_CH'($urandom) : readyFix;
    #5;
    for (int ch = 0; ch < NUM_CH; ch++)
      chk(dropCount[ch*CW +: CW] == CW'(mDrop[ch]), "R7 drop count", dropCount[ch*CW +: CW], mDrop[ch]);
    chk(destErr == mErr, "R6 error flag", destErr, mErr);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (mTvalid[ch] && mTready[ch]) begin
        popCnt[ch]++;
        if (q[ch].size() == 0) chk(0, "R1 unexpected beat", ch, 0);
        else begin
          e = q[ch].pop_front();
          chk(mTdata[ch*WW +: WW] == e[WW-1:0], "R1 R2 word", mTdata[ch*WW +: WW], e[WW-1:0]);
          chk(mTtype[ch*TYPE_W +: TYPE_W] == e[TYPE_W+WW-1:WW], "R2 type", mTtype[ch*TYPE_W +: TYPE_W], e[TYPE_W+WW-1:WW]);
          chk(mTlast[ch] == e[WW-1], "R2 last", mTlast[ch], e[WW-1]);
        end
      end
    end
    eff = mLocked ? mVc : sTdest[1:0];
    expRdy = EN[eff] ? (!mTvalid[eff] || mTready[eff]) : 1'b1;
    if (sTvalid) chk(sTready == expRdy, "R3 ready", sTready, expRdy);
    acc = sTvalid && sTready;
    if (acc) begin
      if (mLocked && sTdest[1:0] != mVc) mErr = 1;
      if (EN[eff]) q[eff].push_back({sTdest[7:2], sTlast, sTuser, sTdata});
      else mDrop[eff] = satInc(mDrop[eff]);
      mLocked = !sTlast;
      mVc = eff;
    end
    @(posedge clk); #1;
  endtask

  task automatic sendBeat(input logic [DW-1:0] d, input logic [7:0] dest, input logic [UW-1:0] u, input logic l);
    bit acc;
    sTdata = d; sTdest = dest; sTuser = u; sTlast = l; sTvalid = 1'b1;
    do evalCycle(acc); while (!acc);
    sTvalid = 1'b0;
  endtask

  task automatic idle(input int n);
    bit acc;
    sTvalid = 1'b0;
    for (int i = 0; i < n; i++) evalCycle(acc);
  endtask

  task automatic sendPkt(input logic [1:0] vc, input int len, input bit corrupt);
    logic [5:0] ty;
    ty = 6'($urandom);
    for (int b = 0; b < len; b++)
      sendBeat(DW'($urandom), {ty, (corrupt && b == 1) ? vc ^ 2'b11 : vc},
               UW'(b == 0), b == len - 1);
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit acc;
    void'($urandom(32'h1357));
    for (int ch = 0; ch < NUM_CH; ch++) popCnt[ch] = 0;
    clearModel();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #4;
    // R9 reset state
    chk(mTvalid == '0, "R9 valid after reset", mTvalid, 0);
    chk(destErr == 1'b0, "R9 error after reset", destErr, 0);
    chk(dropCount == '0, "R9 counters after reset", dropCount, 0);
    @(posedge clk); #1;

    // R8: registered output, one beat held under backpressure, R3 stall
    randReady = 0; readyFix = '0;
    sendBeat(16'hA5A5, {6'h2B, 2'd1}, 1'b1, 1'b1);
    chk(mTvalid == 4'b0010, "R8 R1 one cycle after accept", mTvalid, 4'b0010);
    sTdata = 16'h1111; sTdest = {6'h2B, 2'd1}; sTuser = '0; sTlast = 1'b1; sTvalid = 1'b1;
    evalCycle(acc);
    chk(acc == 1'b0, "R3 full slice stalls input", acc, 0);
    sTvalid = 1'b0;
    readyFix = 4'b1111;
    idle(3);

    // R5 R6: tag change mid-packet stays on the locked channel
    begin
      int before3;
      before3 = popCnt[3];
      sendPkt(2'd0, 3, 1'b1);
      idle(3);
      chk(popCnt[3] == before3, "R5 no beat on channel 3", popCnt[3], before3);
      chk(q[0].size() == 0, "R5 packet drained on channel 0", q[0].size(), 0);
      chk(destErr == 1'b1, "R6 flag set", destErr, 1);
    end

    // R7: disabled channel 2 drops and saturates
    for (int i = 0; i < 18; i++) sendBeat(DW'(i), {6'h05, 2'd2}, 1'b1, 1'b1);
    idle(2);
    chk(dropCount[2*CW +: CW] == 4'hF, "R7 saturated count", dropCount[2*CW +: CW], 4'hF);
    chk(popCnt[2] == 0, "R7 nothing on disabled output", popCnt[2], 0);

    // random traffic with random backpressure
    randReady = 1;
    for (int p = 0; p < 400; p++) begin
      int len;
      len = 1 + ($urandom % 4);
      sendPkt(2'($urandom), len, (len > 1) && (($urandom % 12) == 0));
      if (($urandom % 3) == 0) idle(1 + ($urandom % 3));
    end
    randReady = 0; readyFix = 4'b1111;
    idle(10);
    for (int ch = 0; ch < NUM_CH; ch++)
      chk(q[ch].size() == 0, "R4 R1 every beat delivered", q[ch].size(), 0);

    // R9 mid-packet reset clears lock
    readyFix = '0;
    sendBeat(16'h7777, {6'h11, 2'd3}, 1'b1, 1'b0);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    clearModel();
    #4;
    chk(mTvalid == '0, "R9 valid cleared", mTvalid, 0);
    chk(destErr == 1'b0, "R9 error cleared", destErr, 0);
    chk(dropCount == '0, "R9 counters cleared", dropCount, 0);
    @(posedge clk); #1;
    readyFix = 4'b1111;
    sendBeat(16'h0F0F, {6'h12, 2'd0}, 1'b1, 1'b1);
    chk(mTvalid == 4'b0001, "R9 R5 lock released by reset", mTvalid, 4'b0001);
    idle(3);
    chk(q[0].size() == 0, "R9 beat delivered on channel 0", q[0].size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule